// File: doc/BRIEF.md
# Vectored Interrupt Controller with Rotating Priority

This block collects 64 interrupt inputs and presents them to a processor through a small 32-bit register port with byte enables. Each input has a control byte that switches it on or off, picks level or edge sensing, and sends it to one of eight destinations. These are the normal interrupt line, the fast interrupt line and six auxiliary lines. Edge events are caught in sticky status bits, and software clears them by writing ones. A level input is reported live.

For the normal and the fast line, the controller works out which pending input should be served next and returns its number in a readable register. A per-line priority register chooses between a fixed order (lower number wins) and a rotating order. In the rotating order, an input that has just been served drops to the bottom once its pending state goes away. When no input is pending the number register reads 63. Software tells this apart from a real input 63 by looking at status bit 63.

Top module: `vic_top`

## Requirements
- R1: Control bytes live at byte offsets 0x40..0x7F. The byte for input n is byte lane n mod 4 of the word at 0x40 + 4*(n/4). Each lane is written only when its byte enable is set, and the word reads back exactly what was written.
- R2: Bit 3 of a control byte enables the input. A disabled input drives no destination output and never takes part in arbitration.
- R3: Control bits 2:0 choose the destination: 0 = irqOut, 1 = fiqOut, 2..7 = auxOut[0]..auxOut[5]. Each output is high exactly when some enabled, pending input selects it.
- R4: With control bits 6:5 = 00 the input is level (active high). Its status bit reads the live input ANDed with the enable, and writing 1 to that bit changes nothing.
- R5: Control bit 5 makes an input sense rising edges and bit 6 makes it sense falling edges. A detected edge sets the status bit one clock later even while the input is disabled, but the bit drives outputs only while the input is enabled.
- R6: Status word 0x80 holds inputs 0..31 and word 0x84 holds inputs 32..63 (bit = n mod 32). Writing 1 clears a latched edge bit, but only in byte lanes whose enable is set. Writing 0 leaves the bit unchanged.
- R7: Register 0x00 returns in bits 5:0 the number of the winning pending input routed to irqOut, or 63 when none is pending. In fixed mode the lowest pending number wins.
- R8: Priority register 0x20 (irqOut) has rotate-enable at bit 6 and a field at bits 5:0 naming the lowest-priority input. In rotate mode the search starts at field+1 and wraps. When the current winner stops being pending, the field takes that winner's number one clock later.
- R9: Register 0x04 and priority register 0x24 do the same for inputs routed to fiqOut. In fixed mode the 5:0 field is ignored.
- R10: After reset all control bytes, status bits and both priority registers are zero, all outputs are low, and both number registers read 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register access |
| wrEn | input | 1 | Write strobe, one cycle per write |
| byteEn | input | 4 | Byte lane enables for writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for busAddr, combinational |
| srcIn | input | 64 | Interrupt inputs |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |
| auxOut | output | 6 | Auxiliary destination requests |

## Verification
The bench checks that an input sitting at number 63 reads the same as idle, and that only status bit 63 tells them apart. A design that blended the two would hide real requests. It checks that an edge caught while an input is disabled stays latched and only raises the output after enabling. A design that gated the detector with the enable would lose such events. It checks that a write with only one byte lane enabled clears only the status bits in that lane, and that writing ones to a level input's bit does nothing. It also walks the rotating order through several clears. A design that rotated on every cycle, or never rotated, would serve the wrong input second.

// File: rtl/vic_pkg.sv
package vic_pkg;
  parameter int NSRC   = 64;
  parameter int NDEST  = 8;
  parameter int NCH    = 2;
  parameter int DW     = 32;
  parameter int AW     = 8;
  localparam int IDX_W = $clog2(NSRC);
  localparam int BE_W  = DW / 8;
  localparam int NWORD = NSRC / BE_W;
  localparam int WD_W  = $clog2(NWORD);

  typedef enum logic [2:0] {
    RD_NONE, RD_NUM, RD_PRIO, RD_CTL, RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic            ctlWr;
    logic            statWr;
    logic            prioWr;
    rdSel_e          rdSel;
    logic [WD_W-1:0] word;
    logic [BE_W-1:0] be;
    logic [DW-1:0]   data;
  } strobe_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic [AW-1:0]   busAddr,
  input  logic            wrEn,
  input  logic [BE_W-1:0] byteEn,
  input  logic [DW-1:0]   wrData,
  output strobe_t         stb
);
  logic isNum, isPrio, isCtl, isStat;

  always_comb begin
    isNum  = (busAddr[7:3] == 5'b00000);
    isPrio = (busAddr[7:3] == 5'b00100);
    isCtl  = (busAddr[7:6] == 2'b01);
    isStat = (busAddr[7:3] == 5'b10000);

    stb        = '0;
    stb.be     = byteEn;
    stb.data   = wrData;
    stb.ctlWr  = wrEn && isCtl;
    stb.statWr = wrEn && isStat;
    stb.prioWr = wrEn && isPrio;
    stb.word   = isCtl ? busAddr[WD_W+1:2] : WD_W'(busAddr[2]);
    if (isNum)       stb.rdSel = RD_NUM;
    else if (isPrio) stb.rdSel = RD_PRIO;
    else if (isCtl)  stb.rdSel = RD_CTL;
    else if (isStat) stb.rdSel = RD_STAT;
    else             stb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/vic_arb.sv
module vic_arb
  import vic_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  input  logic             rotate,
  input  logic [IDX_W-1:0] lowPtr,
  output logic [IDX_W-1:0] winIdx,
  output logic             winValid
);
  logic [IDX_W-1:0]  start;
  logic [2*NSRC-1:0] doubled;
  logic [NSRC-1:0]   rotVec;
  logic [IDX_W-1:0]  firstBit;

  always_comb begin
    start    = rotate ? lowPtr + IDX_W'(1) : '0;
    doubled  = {pend, pend} >> start;
    rotVec   = doubled[NSRC-1:0];
    firstBit = '0;
    winValid = 1'b0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (rotVec[k]) begin
        firstBit = IDX_W'(k);
        winValid = 1'b1;
      end
    end
    winIdx = winValid ? firstBit + start : IDX_W'(NSRC - 1);
  end
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [NSRC-1:0]  srcIn,
  output logic [DW-1:0]    rdData,
  output logic [NDEST-1:0] destOut
);
  logic [7:0]       ctlByte [NSRC];
  logic [NSRC-1:0]  prevIn, edgeLatch, edgeHit, enBit, isEdge, pendVec, statusVec;
  logic [NDEST-1:0][NSRC-1:0] destPend;
  logic [6:0]       prio     [NCH];
  logic [IDX_W-1:0] winIdx   [NCH];
  logic             winValid [NCH];
  logic [IDX_W-1:0] lastWin  [NCH];
  logic             lastValid[NCH];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int WI = i / BE_W;
    localparam int BI = i % BE_W;
    localparam int SW = i / DW;
    localparam int SB = (i % DW) / 8;
    localparam int SX = i % DW;
    logic riseEv, fallEv;

    assign enBit[i]     = ctlByte[i][3];
    assign isEdge[i]    = ctlByte[i][5] | ctlByte[i][6];
    assign riseEv       = srcIn[i] & ~prevIn[i];
    assign fallEv       = ~srcIn[i] & prevIn[i];
    assign edgeHit[i]   = (riseEv & ctlByte[i][5]) | (fallEv & ctlByte[i][6]);
    assign statusVec[i] = isEdge[i] ? edgeLatch[i] : (srcIn[i] & enBit[i]);
    assign pendVec[i]   = enBit[i] & (isEdge[i] ? edgeLatch[i] : srcIn[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctlByte[i]   <= '0;
        edgeLatch[i] <= 1'b0;
        prevIn[i]    <= 1'b0;
      end else begin
        prevIn[i] <= srcIn[i];
        if (stb.ctlWr && stb.word == WD_W'(WI) && stb.be[BI])
          ctlByte[i] <= stb.data[8*BI +: 8];
        if (edgeHit[i])
          edgeLatch[i] <= 1'b1;
        else if (stb.statWr && stb.word == WD_W'(SW) && stb.be[SB] && stb.data[SX])
          edgeLatch[i] <= 1'b0;
      end
    end

    for (genvar d = 0; d < NDEST; d++) begin : g_dst
      assign destPend[d][i] = pendVec[i] && (ctlByte[i][2:0] == 3'(d));
    end
  end

  for (genvar d = 0; d < NDEST; d++) begin : g_out
    assign destOut[d] = |destPend[d];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vic_arb u_arb (
      .pend    (destPend[c]),
      .rotate  (prio[c][6]),
      .lowPtr  (prio[c][5:0]),
      .winIdx  (winIdx[c]),
      .winValid(winValid[c])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio[c]      <= '0;
        lastWin[c]   <= '0;
        lastValid[c] <= 1'b0;
      end else begin
        lastWin[c]   <= winIdx[c];
        lastValid[c] <= winValid[c];
        if (stb.prioWr && stb.word == WD_W'(c) && stb.be[0])
          prio[c] <= stb.data[6:0];
        else if (prio[c][6] && lastValid[c] && !destPend[c][lastWin[c]])
          prio[c][5:0] <= lastWin[c];
      end
    end

    // R8/R9: in rotate mode the winner equals the pointer only when alone
    a_r8_ptr_last: assert property (@(posedge clk) disable iff (!rst_n)
      (prio[c][6] && winValid[c] && winIdx[c] == prio[c][5:0])
        |-> ($countones(destPend[c]) == 1));

    // R7: fixed order picks the lowest pending number
    a_r7_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (!prio[c][6] && winValid[c])
        |-> ((destPend[c] & ((NSRC'(1) << winIdx[c]) - NSRC'(1))) == '0));

    // R7: idle reads as the top number
    a_r7_idle_63: assert property (@(posedge clk) disable iff (!rst_n)
      (destPend[c] == '0) |-> (winIdx[c] == IDX_W'(NSRC - 1) && !winValid[c]));

    // R3: request output agrees with the arbiter
    a_r3_out_valid: assert property (@(posedge clk) disable iff (!rst_n)
      destOut[c] == winValid[c]);
  end

  // R5: a detected edge is latched on the next clock
  a_r5_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeHit != '0) |=> ((edgeLatch & $past(edgeHit)) == $past(edgeHit)));

  always_comb begin
    rdData = '0;
    case (stb.rdSel)
      RD_NUM:  rdData = DW'(winIdx[stb.word[0]]);
      RD_PRIO: rdData = DW'(prio[stb.word[0]]);
      RD_CTL:
        for (int k = 0; k < BE_W; k++)
          rdData[8*k +: 8] = ctlByte[BE_W*stb.word + k];
      RD_STAT: rdData = statusVec[DW*stb.word[0] +: DW];
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  busAddr,
  input  logic        wrEn,
  input  logic [3:0]  byteEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic [63:0] srcIn,
  output logic        irqOut,
  output logic        fiqOut,
  output logic [5:0]  auxOut
);
  strobe_t    stb;
  logic [NDEST-1:0] destOut;

  vic_ctrl u_ctrl (
    .busAddr(busAddr),
    .wrEn   (wrEn),
    .byteEn (byteEn),
    .wrData (wrData),
    .stb    (stb)
  );

  vic_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .srcIn  (srcIn),
    .rdData (rdData),
    .destOut(destOut)
  );

  assign irqOut = destOut[0];
  assign fiqOut = destOut[1];
  assign auxOut = destOut[7:2];
endmodule

// File: tb/vic_top_bench.sv
`timescale 1ns/1ps
module vic_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  byteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] srcIn = '0;
  logic        irqOut, fiqOut;
  logic [5:0]  auxOut;
  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  vic_top u_vic_top (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .wrEn(wrEn), .byteEn(byteEn),
    .wrData(wrData), .rdData(rdData), .srcIn(srcIn), .irqOut(irqOut),
    .fiqOut(fiqOut), .auxOut(auxOut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; srcIn = '0; wrEn = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    busAddr = a; wrData = d; byteEn = be; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic setCtl(int n, logic [7:0] v);
    wr(8'(8'h40 + 4 * (n / 4)), 32'(v) << (8 * (n % 4)), 4'(1 << (n % 4)));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    doReset();
    rd(8'h40, d); chk("R10 ctl reset", d, 0);
    rd(8'h7C, d); chk("R10 ctl reset hi", d, 0);
    rd(8'h20, d); chk("R10 irq prio reset", d, 0);
    rd(8'h24, d); chk("R10 fiq prio reset", d, 0);
    rd(8'h00, d); chk("R10 irq num idle", d, 63);
    rd(8'h04, d); chk("R10 fiq num idle", d, 63);
    chk("R10 outputs low", {irqOut, fiqOut, auxOut}, 0);
  endtask

  task automatic t_ctlBytes();
    logic [31:0] d;
    doReset();
    wr(8'h44, 32'h00AB0000, 4'b0100);
    rd(8'h44, d); chk("R1 single lane write", d, 32'h00AB0000);
    wr(8'h44, 32'hFFFF0011, 4'b0001);
    rd(8'h44, d); chk("R1 other lanes kept", d, 32'h00AB0011);
  endtask

  task automatic t_level();
    logic [31:0] d;
    doReset();
    setCtl(5, 8'h08);
    setCtl(6, 8'h00);
    srcIn[6] = 1'b1; tick(1);
    chk("R2 disabled no irq", irqOut, 0);
    rd(8'h80, d); chk("R4 disabled level status 0", d, 0);
    srcIn[5] = 1'b1; tick(1);
    chk("R3 level irq", irqOut, 1);
    rd(8'h00, d); chk("R7 num level", d, 5);
    wr(8'h80, 32'h20);
    rd(8'h80, d); chk("R4 write1 ignored on level", d, 32'h20);
    srcIn[5] = 1'b0; tick(1);
    chk("R4 level follows input", irqOut, 0);
    rd(8'h00, d); chk("R7 idle after drop", d, 63);
  endtask

  task automatic t_route();
    logic [31:0] d;
    doReset();
    setCtl(10, 8'h09);
    setCtl(11, 8'h0F);
    setCtl(12, 8'h0A);
    srcIn[12:10] = 3'b111; tick(1);
    chk("R3 fiq routed", fiqOut, 1);
    chk("R3 irq not routed", irqOut, 0);
    chk("R3 aux0 and aux5", auxOut, 6'b100001);
    rd(8'h04, d); chk("R9 fiq num", d, 10);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    doReset();
    setCtl(40, 8'h28);
    setCtl(41, 8'h48);
    setCtl(42, 8'h20);
    setCtl(32, 8'h28);
    srcIn[40] = 1'b1; srcIn[32] = 1'b1; tick(1);
    srcIn[40] = 1'b0; srcIn[32] = 1'b0; tick(1);
    rd(8'h84, d); chk("R5 rising latched", d, 32'h101);
    chk("R5 edge drives irq", irqOut, 1);
    wr(8'h84, 32'h0);
    rd(8'h84, d); chk("R6 zero write keeps", d, 32'h101);
    wr(8'h84, 32'hFFFFFFFF, 4'b0010);
    rd(8'h84, d); chk("R6 byte lane clear only", d, 32'h001);
    wr(8'h84, 32'h1);
    rd(8'h84, d); chk("R6 clear word1", d, 0);
    srcIn[41] = 1'b1; tick(2);
    rd(8'h84, d); chk("R5 falling ignores rise", d, 0);
    srcIn[41] = 1'b0; tick(1);
    rd(8'h84, d); chk("R5 falling latched", d, 32'h200);
    wr(8'h84, 32'h200);
    srcIn[42] = 1'b1; tick(1);
    srcIn[42] = 1'b0; tick(1);
    rd(8'h84, d); chk("R5 latched while disabled", d, 32'h400);
    chk("R5 disabled edge no irq", irqOut, 0);
    setCtl(42, 8'h28);
    chk("R5 enable releases irq", irqOut, 1);
    rd(8'h00, d); chk("R7 num edge", d, 42);
  endtask

  task automatic t_fixed();
    logic [31:0] d;
    doReset();
    setCtl(63, 8'h08);
    srcIn[63] = 1'b1; tick(1);
    rd(8'h00, d); chk("R7 real 63 number", d, 63);
    rd(8'h84, d); chk("R7 status bit 63 set", d[31], 1);
    srcIn[63] = 1'b0; tick(1);
    rd(8'h84, d); chk("R7 idle bit 63 clear", d[31], 0);
    setCtl(3, 8'h08); setCtl(9, 8'h08);
    srcIn[9] = 1'b1; srcIn[3] = 1'b1; tick(1);
    rd(8'h00, d); chk("R7 lowest wins", d, 3);
    setCtl(1, 8'h09); setCtl(8, 8'h09);
    wr(8'h24, 32'h05);
    srcIn[8] = 1'b1; srcIn[1] = 1'b1; tick(1);
    rd(8'h04, d); chk("R9 fixed ignores field", d, 1);
  endtask

  task automatic t_rotate();
    logic [31:0] d;
    doReset();
    wr(8'h20, 32'h40);
    setCtl(2, 8'h28); setCtl(7, 8'h28);
    srcIn[2] = 1'b1; srcIn[7] = 1'b1; tick(1);
    srcIn[2] = 1'b0; srcIn[7] = 1'b0; tick(1);
    rd(8'h00, d); chk("R8 start after ptr", d, 2);
    wr(8'h80, 32'h4); tick(1);
    rd(8'h20, d); chk("R8 ptr takes winner", d, 32'h42);
    rd(8'h00, d); chk("R8 next winner", d, 7);
    srcIn[2] = 1'b1; tick(1);
    srcIn[2] = 1'b0; tick(1);
    rd(8'h00, d); chk("R8 served one is last", d, 7);
    wr(8'h80, 32'h80); tick(1);
    rd(8'h20, d); chk("R8 ptr to 7", d, 32'h47);
    rd(8'h00, d); chk("R8 wrap to 2", d, 2);
    wr(8'h80, 32'h4); tick(1);
    rd(8'h20, d); chk("R8 ptr after last clear", d, 32'h42);
    rd(8'h00, d); chk("R8 idle", d, 63);
  endtask

  task automatic t_fiqRotate();
    logic [31:0] d;
    doReset();
    wr(8'h24, 32'h45);
    setCtl(1, 8'h09); setCtl(8, 8'h09);
    srcIn[1] = 1'b1; srcIn[8] = 1'b1; tick(1);
    rd(8'h04, d); chk("R9 fiq rotate order", d, 8);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ctlBytes();
        t_level();
        t_route();
        t_edge();
        t_fixed();
        t_rotate();
        t_fiqRotate();
      end
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule